// File: doc/BRIEF.md
# Effective Address Generation Unit

This block forms the operand address for a 32-bit load/store datapath that supports a family of register, absolute, program-counter-relative and immediate operand forms. In one combinational step it takes a mode code, an operand size, an address register number, an index value, the address of the first extension word and two 16-bit extension words. From these it yields the effective address, the count of extension words consumed, a flag that separates program references from data references, and the updated register value for the auto-increment and auto-decrement forms.

The eight address registers live inside the block. A separate load port writes them. A write-back from an auto-increment or auto-decrement operation takes effect at the next rising clock edge when the request strobe is high. Register 7 is the stack pointer, and it never steps by one byte. In the immediate form the output carries the operand value itself rather than an address.

Top module: `ea_gen_unit`

## Requirements
- R1: After reset all eight address registers read as zero, so mode 0 gives ea_o = 0 for every register number.
- R2: Mode 0 (register indirect) gives ea_o = An, where An is the register selected by areg_i. It raises no write-back (an_we_o = 0) and uses zero extension words.
- R3: Mode 1 (post-increment) gives ea_o = An and an_wdata_o = An + step. The step is 1, 2 or 4 for size_i = 0 (byte), 1 (word) or 2 (long). With req_i high, an_we_o = 1.
- R4: Mode 2 (pre-decrement) gives an_wdata_o = An - step and ea_o = An - step. With req_i high, an_we_o = 1.
- R5: When areg_i = 7 and size_i = 0, modes 1 and 2 step by 2 instead of 1.
- R6: Mode 3 (displacement) gives ea_o = An + sign-extended ext0_i, with ext_cnt_o = 1.
- R7: Mode 4 (indexed) gives ea_o = An + sign-extended ext0_i[7:0] + index_i, with ext_cnt_o = 1.
- R8: Mode 5 (absolute short) gives ea_o = sign-extended ext0_i with ext_cnt_o = 1. Mode 6 (absolute long) gives ea_o = {ext0_i, ext1_i} with ext_cnt_o = 2.
- R9: Mode 7 gives pc_i + sign-extended ext0_i. Mode 8 gives pc_i + sign-extended ext0_i[7:0] + index_i. Both use ext_cnt_o = 1, and pc_i is the address of the first extension word. prog_ref_o is 1 only in modes 7 and 8.
- R10: Mode 9 (immediate) raises imm_o. ea_o then carries the operand: ext0_i[7:0] zero-extended for byte, ext0_i zero-extended for word (both with ext_cnt_o = 1), or {ext0_i, ext1_i} for long (ext_cnt_o = 2).
- R11: A register changes only at a rising edge, and only through one of two paths. One is a write-back (req_i high with an_we_o = 1), which stores an_wdata_o. The other is the load port, which stores ld_data_i when ld_en_i is high. When both paths target the same register in one cycle, the load port wins. With req_i low there is no write-back.
- R12: Mode codes 10 to 15, or size_i = 3, raise illegal_o. The block then drives ea_o = 0, ext_cnt_o = 0, an_we_o = 0, prog_ref_o = 0 and imm_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Operation strobe; allows write-back |
| mode_i | input | 4 | Operand mode code 0 to 9 |
| size_i | input | 2 | 0 byte, 1 word, 2 long |
| areg_i | input | 3 | Address register number |
| index_i | input | 32 | Index register value |
| pc_i | input | 32 | Address of the first extension word |
| ext0_i | input | 16 | First extension word |
| ext1_i | input | 16 | Second extension word |
| ld_en_i | input | 1 | Register load enable |
| ld_sel_i | input | 3 | Register load number |
| ld_data_i | input | 32 | Register load value |
| ea_o | output | 32 | Effective address or immediate value |
| an_wdata_o | output | 32 | Updated register value |
| an_we_o | output | 1 | Write-back enable |
| ext_cnt_o | output | 2 | Extension words consumed |
| prog_ref_o | output | 1 | Program reference flag |
| imm_o | output | 1 | Output is an operand value |
| illegal_o | output | 1 | Unused mode or size code |

## Verification
The hardest case to reach from the ports is a write-back and a load to the same register in the same cycle, because random register numbers seldom line up. A directed step forces that collision and then reads the register back through mode 0. The stack-pointer byte step is also directed, in both directions. The bench keeps its own shadow of the register file, and the random sequence of post-increment and pre-decrement operations is checked against that shadow over several hundred operations.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [3:0] {
    EA_IND     = 4'd0,
    EA_POSTINC = 4'd1,
    EA_PREDEC  = 4'd2,
    EA_DISP    = 4'd3,
    EA_IDX     = 4'd4,
    EA_ABS_S   = 4'd5,
    EA_ABS_L   = 4'd6,
    EA_PC_DISP = 4'd7,
    EA_PC_IDX  = 4'd8,
    EA_IMM     = 4'd9
  } ea_mode_e;

  typedef enum logic [1:0] {
    SZ_B   = 2'd0,
    SZ_W   = 2'd1,
    SZ_L   = 2'd2,
    SZ_RSV = 2'd3
  } ea_size_e;
endpackage

// File: rtl/ea_areg_file.sv
module ea_areg_file #(
  parameter int NREG = 8,
  parameter int AW   = 32,
  parameter int SW   = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] rd_sel_i,
  output logic [AW-1:0] rd_data_o,
  input  logic          wb_en_i,
  input  logic [SW-1:0] wb_sel_i,
  input  logic [AW-1:0] wb_data_i,
  input  logic          ld_en_i,
  input  logic [SW-1:0] ld_sel_i,
  input  logic [AW-1:0] ld_data_i
);
  logic [AW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        regs[g] <= '0;
      else if (ld_en_i && ld_sel_i == SW'(g))  // load port has priority
        regs[g] <= ld_data_i;
      else if (wb_en_i && wb_sel_i == SW'(g))
        regs[g] <= wb_data_i;
    end
  end

  assign rd_data_o = regs[rd_sel_i];
endmodule

// File: rtl/ea_step.sv
module ea_step #(
  parameter int AW     = 32,
  parameter int SW     = 3,
  parameter int SP_IDX = 7
) (
  input  logic [1:0]    size_i,
  input  logic [SW-1:0] sel_i,
  output logic [AW-1:0] step_o
);
  import ea_pkg::*;

  always_comb begin
    unique case (ea_size_e'(size_i))
      SZ_B:    step_o = (sel_i == SW'(SP_IDX)) ? AW'(2) : AW'(1);
      SZ_W:    step_o = AW'(2);
      SZ_L:    step_o = AW'(4);
      default: step_o = '0;
    endcase
  end
endmodule

// File: rtl/ea_calc.sv
module ea_calc #(
  parameter int AW   = 32,
  parameter int EXTW = 16
) (
  input  logic [3:0]      mode_i,
  input  logic [1:0]      size_i,
  input  logic [AW-1:0]   base_i,
  input  logic [AW-1:0]   index_i,
  input  logic [AW-1:0]   pc_i,
  input  logic [EXTW-1:0] ext0_i,
  input  logic [EXTW-1:0] ext1_i,
  input  logic [AW-1:0]   step_i,
  output logic [AW-1:0]   ea_o,
  output logic [AW-1:0]   wdata_o,
  output logic            upd_o,
  output logic [1:0]      ext_cnt_o,
  output logic            prog_o,
  output logic            imm_o,
  output logic            illegal_o
);
  import ea_pkg::*;

  logic [AW-1:0] sx16, sx8, cat32, idx_off, pc_dec;

  assign sx16    = {{(AW-EXTW){ext0_i[EXTW-1]}}, ext0_i};
  assign sx8     = {{(AW-8){ext0_i[7]}}, ext0_i[7:0]};
  assign cat32   = AW'({ext0_i, ext1_i});
  assign idx_off = sx8 + index_i;
  assign pc_dec  = base_i - step_i;

  always_comb begin
    ea_o      = '0;
    wdata_o   = '0;
    upd_o     = 1'b0;
    ext_cnt_o = 2'd0;
    prog_o    = 1'b0;
    imm_o     = 1'b0;
    illegal_o = 1'b0;
    if (ea_size_e'(size_i) == SZ_RSV) begin
      illegal_o = 1'b1;
    end else begin
      unique case (mode_i)
        EA_IND:     ea_o = base_i;
        EA_POSTINC: begin
          ea_o    = base_i;
          wdata_o = base_i + step_i;
          upd_o   = 1'b1;
        end
        EA_PREDEC: begin
          ea_o    = pc_dec;
          wdata_o = pc_dec;
          upd_o   = 1'b1;
        end
        EA_DISP:  begin ea_o = base_i + sx16;  ext_cnt_o = 2'd1; end
        EA_IDX:   begin ea_o = base_i + idx_off; ext_cnt_o = 2'd1; end
        EA_ABS_S: begin ea_o = sx16;  ext_cnt_o = 2'd1; end
        EA_ABS_L: begin ea_o = cat32; ext_cnt_o = 2'd2; end
        EA_PC_DISP: begin
          ea_o = pc_i + sx16; ext_cnt_o = 2'd1; prog_o = 1'b1;
        end
        EA_PC_IDX: begin
          ea_o = pc_i + idx_off; ext_cnt_o = 2'd1; prog_o = 1'b1;
        end
        EA_IMM: begin
          imm_o = 1'b1;
          unique case (ea_size_e'(size_i))
            SZ_B:    begin ea_o = AW'(ext0_i[7:0]); ext_cnt_o = 2'd1; end
            SZ_W:    begin ea_o = AW'(ext0_i);      ext_cnt_o = 2'd1; end
            default: begin ea_o = cat32;            ext_cnt_o = 2'd2; end
          endcase
        end
        default: illegal_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/ea_gen_unit.sv
module ea_gen_unit #(
  parameter int AW     = 32,
  parameter int EXTW   = 16,
  parameter int NREG   = 8,
  parameter int SP_IDX = 7,
  parameter int SW     = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [3:0]      mode_i,
  input  logic [1:0]      size_i,
  input  logic [SW-1:0]   areg_i,
  input  logic [AW-1:0]   index_i,
  input  logic [AW-1:0]   pc_i,
  input  logic [EXTW-1:0] ext0_i,
  input  logic [EXTW-1:0] ext1_i,
  input  logic            ld_en_i,
  input  logic [SW-1:0]   ld_sel_i,
  input  logic [AW-1:0]   ld_data_i,
  output logic [AW-1:0]   ea_o,
  output logic [AW-1:0]   an_wdata_o,
  output logic            an_we_o,
  output logic [1:0]      ext_cnt_o,
  output logic            prog_ref_o,
  output logic            imm_o,
  output logic            illegal_o
);
  logic [AW-1:0] an_rdata;
  logic [AW-1:0] step;
  logic          upd;

  ea_areg_file #(.NREG(NREG), .AW(AW), .SW(SW)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_sel_i (areg_i),
    .rd_data_o(an_rdata),
    .wb_en_i  (an_we_o),
    .wb_sel_i (areg_i),
    .wb_data_i(an_wdata_o),
    .ld_en_i  (ld_en_i),
    .ld_sel_i (ld_sel_i),
    .ld_data_i(ld_data_i)
  );

  ea_step #(.AW(AW), .SW(SW), .SP_IDX(SP_IDX)) u_step (
    .size_i(size_i),
    .sel_i (areg_i),
    .step_o(step)
  );

  ea_calc #(.AW(AW), .EXTW(EXTW)) u_calc (
    .mode_i   (mode_i),
    .size_i   (size_i),
    .base_i   (an_rdata),
    .index_i  (index_i),
    .pc_i     (pc_i),
    .ext0_i   (ext0_i),
    .ext1_i   (ext1_i),
    .step_i   (step),
    .ea_o     (ea_o),
    .wdata_o  (an_wdata_o),
    .upd_o    (upd),
    .ext_cnt_o(ext_cnt_o),
    .prog_o   (prog_ref_o),
    .imm_o    (imm_o),
    .illegal_o(illegal_o)
  );

  assign an_we_o = req_i & upd;
endmodule

// File: rtl/ea_gen_unit_chk.sv
module ea_gen_unit_chk #(
  parameter int AW = 32,
  parameter int SW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic [3:0]    mode_i,
  input logic [1:0]    size_i,
  input logic [SW-1:0] areg_i,
  input logic [AW-1:0] an_rdata,
  input logic [AW-1:0] ea_o,
  input logic [AW-1:0] an_wdata_o,
  input logic          an_we_o,
  input logic [1:0]    ext_cnt_o,
  input logic          prog_ref_o,
  input logic          illegal_o
);
  logic legal_sz;
  assign legal_sz = (size_i != 2'd3);

  a_r2_indirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'd0 && legal_sz) |-> (ea_o == an_rdata && !an_we_o && ext_cnt_o == 2'd0));

  a_r3_postinc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i == 4'd1 && legal_sz && size_i != 2'd0) |->
      (an_we_o && ea_o == an_rdata &&
       an_wdata_o - ea_o == ((size_i == 2'd1) ? AW'(2) : AW'(4))));

  a_r4_predec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i == 4'd2 && legal_sz) |-> (an_we_o && ea_o == an_wdata_o));

  a_r5_sp_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'd1 && size_i == 2'd0 && areg_i == SW'(7)) |-> (an_wdata_o - an_rdata == AW'(2)));

  a_r5_sp_byte_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'd2 && size_i == 2'd0 && areg_i == SW'(7)) |-> (an_rdata - ea_o == AW'(2)));

  a_r9_prog_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_ref_o |-> (mode_i == 4'd7 || mode_i == 4'd8));

  a_r11_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> !an_we_o);

  a_r12_illegal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!an_we_o && ext_cnt_o == 2'd0 && !prog_ref_o && ea_o == '0));
endmodule

bind ea_gen_unit ea_gen_unit_chk #(.AW(AW), .SW(SW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .mode_i    (mode_i),
  .size_i    (size_i),
  .areg_i    (areg_i),
  .an_rdata  (an_rdata),
  .ea_o      (ea_o),
  .an_wdata_o(an_wdata_o),
  .an_we_o   (an_we_o),
  .ext_cnt_o (ext_cnt_o),
  .prog_ref_o(prog_ref_o),
  .illegal_o (illegal_o)
);

// File: tb/sim_ea_gen_unit.sv
module sim_ea_gen_unit;
  localparam int PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [3:0]  mode_i = '0;
  logic [1:0]  size_i = '0;
  logic [2:0]  areg_i = '0;
  logic [31:0] index_i = '0, pc_i = '0;
  logic [15:0] ext0_i = '0, ext1_i = '0;
  logic        ld_en_i = 1'b0;
  logic [2:0]  ld_sel_i = '0;
  logic [31:0] ld_data_i = '0;
  logic [31:0] ea_o, an_wdata_o;
  logic        an_we_o, prog_ref_o, imm_o, illegal_o;
  logic [1:0]  ext_cnt_o;

  int checks = 0, failures = 0;
  logic [31:0] shadow [8];

  ea_gen_unit u0 (.*);

  always #(PERIOD/2) clk_i = ~clk_i;

  function automatic logic [31:0] sx16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction
  function automatic logic [31:0] sx8(input logic [7:0] v);
    return {{24{v[7]}}, v};
  endfunction
  function automatic logic [31:0] step_of(input logic [1:0] sz, input logic [2:0] r);
    if (sz == 2'd0) return (r == 3'd7) ? 32'd2 : 32'd1;
    return (sz == 2'd1) ? 32'd2 : 32'd4;
  endfunction

  // {illegal, imm, prog, cnt[1:0], we, wdata[31:0], ea[31:0]}
  function automatic logic [69:0] expect_of(input logic rq, input logic [3:0] m,
      input logic [1:0] sz, input logic [31:0] an, input logic [2:0] r,
      input logic [31:0] ix, input logic [31:0] pc, input logic [15:0] e0, input logic [15:0] e1);
    logic [31:0] ea, wd;
    logic [1:0] cnt;
    logic we, prog, imm, ill;
    ea = '0; wd = '0; cnt = '0; we = 0; prog = 0; imm = 0; ill = 0;
    if (sz == 2'd3 || m > 4'd9) ill = 1;
    else case (m)
      4'd0: ea = an;
      4'd1: begin ea = an; wd = an + step_of(sz, r); we = rq; end
      4'd2: begin ea = an - step_of(sz, r); wd = ea; we = rq; end
      4'd3: begin ea = an + sx16(e0); cnt = 1; end
      4'd4: begin ea = an + sx8(e0[7:0]) + ix; cnt = 1; end
      4'd5: begin ea = sx16(e0); cnt = 1; end
      4'd6: begin ea = {e0, e1}; cnt = 2; end
      4'd7: begin ea = pc + sx16(e0); cnt = 1; prog = 1; end
      4'd8: begin ea = pc + sx8(e0[7:0]) + ix; cnt = 1; prog = 1; end
      default: begin
        imm = 1;
        if (sz == 2'd0) begin ea = {24'd0, e0[7:0]}; cnt = 1; end
        else if (sz == 2'd1) begin ea = {16'd0, e0}; cnt = 1; end
        else begin ea = {e0, e1}; cnt = 2; end
      end
    endcase
    if (!we) wd = '0;
    return {ill, imm, prog, cnt, we, wd, ea};
  endfunction

  function automatic string tag_of(input logic [3:0] m, input logic [1:0] sz, input logic [2:0] r);
    if (sz == 2'd3 || m > 4'd9) return "R12";
    case (m)
      4'd0: return "R2";
      4'd1: return (sz == 0 && r == 7) ? "R5" : "R3";
      4'd2: return (sz == 0 && r == 7) ? "R5" : "R4";
      4'd3: return "R6";
      4'd4: return "R7";
      4'd5, 4'd6: return "R8";
      4'd7, 4'd8: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [69:0] act, input logic [69:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic rq, input logic [3:0] m, input logic [1:0] sz,
      input logic [2:0] r, input logic [31:0] ix, input logic [31:0] pc,
      input logic [15:0] e0, input logic [15:0] e1,
      input logic le, input logic [2:0] ls, input logic [31:0] ld, input string tag);
    logic [69:0] exp, act;
    @(negedge clk_i);
    req_i = rq; mode_i = m; size_i = sz; areg_i = r; index_i = ix; pc_i = pc;
    ext0_i = e0; ext1_i = e1; ld_en_i = le; ld_sel_i = ls; ld_data_i = ld;
    #(PERIOD/4);
    exp = expect_of(rq, m, sz, shadow[r], r, ix, pc, e0, e1);
    act = {illegal_o, imm_o, prog_ref_o, ext_cnt_o, an_we_o,
           an_we_o ? an_wdata_o : 32'd0, ea_o};
    check((tag == "") ? tag_of(m, sz, r) : tag, act, exp);
    @(posedge clk_i);
    if (exp[64] && !(le && ls == r)) shadow[r] = exp[63:32];
    if (le) shadow[ls] = ld;
  endtask

  initial begin
    #(PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 8; i++) shadow[i] = '0;
    #(PERIOD * 2 + 1);
    rst_ni = 1'b1;
    // R1: reset state
    for (int i = 0; i < 8; i++)
      do_op(1, 4'd0, 2'd2, 3'(i), 0, 0, 0, 0, 0, 0, 0, "R1");
    // load registers through the load port
    for (int i = 0; i < 8; i++)
      do_op(0, 4'd0, 2'd2, 3'(i), 0, 0, 0, 0, 1, 3'(i), 32'h1000_0000 + 32'(i * 256), "R11");
    // R5: stack pointer byte steps, both directions
    do_op(1, 4'd1, 2'd0, 3'd7, 0, 0, 0, 0, 0, 0, 0, "R5");
    do_op(1, 4'd2, 2'd0, 3'd7, 0, 0, 0, 0, 0, 0, 0, "R5");
    do_op(1, 4'd2, 2'd0, 3'd7, 0, 0, 0, 0, 0, 0, 0, "R5");
    do_op(1, 4'd1, 2'd0, 3'd3, 0, 0, 0, 0, 0, 0, 0, "R3");
    // R11: write-back then readback; no req means no update
    do_op(1, 4'd1, 2'd2, 3'd2, 0, 0, 0, 0, 0, 0, 0, "R3");
    do_op(1, 4'd0, 2'd2, 3'd2, 0, 0, 0, 0, 0, 0, 0, "R11");
    do_op(0, 4'd2, 2'd1, 3'd2, 0, 0, 0, 0, 0, 0, 0, "R11");
    do_op(1, 4'd0, 2'd2, 3'd2, 0, 0, 0, 0, 0, 0, 0, "R11");
    // R11: load and write-back collide on one register, load wins
    do_op(1, 4'd1, 2'd2, 3'd5, 0, 0, 0, 0, 1, 3'd5, 32'hCAFE_0000, "R11");
    do_op(1, 4'd0, 2'd2, 3'd5, 0, 0, 0, 0, 0, 0, 0, "R11");
    // directed sign-extension corners
    do_op(1, 4'd3, 2'd1, 3'd1, 0, 0, 16'h8000, 0, 0, 0, 0, "R6");
    do_op(1, 4'd4, 2'd1, 3'd1, 32'hFFFF_FFF0, 0, 16'h1280, 0, 0, 0, 0, "R7");
    do_op(1, 4'd5, 2'd1, 3'd0, 0, 0, 16'hFFFE, 0, 0, 0, 0, "R8");
    do_op(1, 4'd6, 2'd2, 3'd0, 0, 0, 16'hDEAD, 16'hBEEF, 0, 0, 0, "R8");
    do_op(1, 4'd7, 2'd1, 3'd0, 0, 32'h0000_0100, 16'hFF00, 0, 0, 0, 0, "R9");
    do_op(1, 4'd8, 2'd1, 3'd0, 32'd4, 32'h0000_0100, 16'h00FF, 0, 0, 0, 0, "R9");
    do_op(1, 4'd9, 2'd0, 3'd0, 0, 0, 16'hABCD, 16'h1111, 0, 0, 0, "R10");
    do_op(1, 4'd9, 2'd1, 3'd0, 0, 0, 16'hABCD, 16'h1111, 0, 0, 0, "R10");
    do_op(1, 4'd9, 2'd2, 3'd0, 0, 0, 16'hABCD, 16'h1111, 0, 0, 0, "R10");
    do_op(1, 4'd10, 2'd1, 3'd0, 0, 0, 0, 0, 0, 0, 0, "R12");
    do_op(1, 4'd1, 2'd3, 3'd0, 0, 0, 0, 0, 0, 0, 0, "R12");
    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      logic [3:0] m;
      logic [1:0] sz;
      m  = ($urandom % 8 == 0) ? 4'(10 + $urandom % 6) : 4'($urandom % 10);
      sz = ($urandom % 16 == 0) ? 2'd3 : 2'($urandom % 3);
      do_op(($urandom % 10) != 0, m, sz, 3'($urandom), $urandom, $urandom,
            16'($urandom), 16'($urandom), ($urandom % 8) == 0, 3'($urandom), $urandom, "");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule